// File: doc/BRIEF.md
# Operand Address Generation Unit

This block takes one operand specifier at a time and turns it into an effective address and an operand value. A specifier is a 3-bit mode code, an address or displacement field, a register index, the current program counter and a step-direction flag. All of these are presented with a one-cycle start strobe. The block reads the named register through a combinational register-file read port in the same cycle as the strobe. It then issues zero, one or two reads on a request/valid memory port, depending on the mode. When it finishes, it raises a one-cycle completion pulse with the effective address and operand.

The auto-stepping mode also updates its base register. The new pointer value goes out on a write-back port with a one-cycle enable, in the same cycle as completion. The surrounding pipeline waits for the completion pulse before presenting the next specifier. A strobe that arrives while memory reads are outstanding is dropped.

Top module: `opaddr_gen`

## Requirements
- R1: Mode code 0 (immediate) returns the field, zero-extended, as the operand. The effective address output reads 0, no memory read is issued, and completion is signalled in the cycle after the strobe is sampled.
- R2: Mode code 1 (register) returns the named register's value as the operand. The effective address output reads 0, no memory read is issued, and completion is signalled in the cycle after the strobe.
- R3: Mode code 2 (direct) uses the zero-extended field as the effective address. It performs exactly one memory read there and returns the data as the operand.
- R4: Mode code 3 (memory-indirect) reads memory at the zero-extended field first and takes the returned word as the effective address. It then reads the operand at that address, for exactly two reads.
- R5: Mode code 4 (register-indirect) uses the named register's value as the effective address and performs exactly one memory read.
- R6: Mode code 5 (displacement) uses the register value plus the sign-extended field as the effective address, wrapping modulo 2^AW. It performs one read.
- R7: Mode code 6 (PC-relative) uses the program counter plus the sign-extended field as the effective address, wrapping modulo 2^AW. It performs one read.
- R8: Mode code 7 with the direction input low (post-increment) uses the register value as the effective address. It writes back register value plus one to the same register index, with a one-cycle write enable in the completion cycle.
- R9: Mode code 7 with the direction input high (pre-decrement) uses register value minus one as the effective address. It writes back that same decremented value with a one-cycle write enable in the completion cycle.
- R10: A memory read request holds its address steady until valid is sampled high. A read completes on the clock edge where both request and valid are high. Completion comes two cycles per read after the strobe, given a memory that answers one cycle after the request.
- R11: A start strobe sampled while a read is outstanding is ignored. The current access completes with its own results, and no further request or completion follows.
- R12: After reset, completion, request, write enable, effective address and operand are all 0. Completion is a single-cycle pulse. The operand output holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new specifier |
| mode_i | input | 3 | Addressing mode code (0..7) |
| dec_i | input | 1 | Step direction for mode 7: 0 post-increment, 1 pre-decrement |
| field_i | input | FW | Address, constant or displacement field |
| rsel_i | input | RI | Register index |
| pc_i | input | AW | Current program counter |
| rf_addr_o | output | RI | Register-file read index |
| rf_data_i | input | AW | Register-file read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_data_i | input | AW | Memory read data |
| ea_o | output | AW | Effective address |
| operand_o | output | AW | Operand value |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | RI | Register write-back index |
| wb_data_o | output | AW | Register write-back value |

## Verification
The completion pulse and the pointer write-back fall in the same cycle. Both are provoked by every mode-7 access. The bench checks, cycle by cycle, that the two appear together exactly two cycles after the strobe and never apart. Its own register model advances independently, so a stepped pointer that is wrong, or written in the wrong cycle, shows up in the next access through the same register. A strobe is also held into the first busy cycle of direct and indirect accesses. The run is judged on the original access finishing unchanged, with no stray request or completion afterwards.

// File: rtl/oagu_pkg.sv
package oagu_pkg;

    typedef enum logic [2:0] {
        AM_IMM   = 3'd0,
        AM_REG   = 3'd1,
        AM_DIR   = 3'd2,
        AM_IND   = 3'd3,
        AM_RIND  = 3'd4,
        AM_DISP  = 3'd5,
        AM_PCREL = 3'd6,
        AM_STEP  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_OPR  = 2'd2
    } ast_e;

    localparam int unsigned MAX_READS = 2;
    localparam int unsigned RCNT_W    = $clog2(MAX_READS + 1);

endpackage

// File: rtl/oagu_ea_calc.sv
module oagu_ea_calc
    import oagu_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned FW = 12
) (
    input  amode_e            mode_i,
    input  logic              dec_i,
    input  logic [FW-1:0]     field_i,
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     pc_i,
    output logic [AW-1:0]     ea_o,
    output logic [AW-1:0]     first_addr_o,
    output logic [AW-1:0]     early_val_o,
    output logic [RCNT_W-1:0] nrd_o,
    output logic              wb_need_o,
    output logic [AW-1:0]     wb_val_o
);

    localparam int unsigned EXT_W = AW - FW;
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] fld_zx;
    logic [AW-1:0] fld_sx;
    logic [AW-1:0] base_inc;
    logic [AW-1:0] base_dec;

    assign fld_zx   = {{EXT_W{1'b0}}, field_i};
    assign fld_sx   = {{EXT_W{field_i[FW-1]}}, field_i};
    assign base_inc = base_i + ONE;
    assign base_dec = base_i - ONE;

    always_comb begin
        ea_o        = '0;
        early_val_o = '0;
        nrd_o       = RCNT_W'(1);
        wb_need_o   = 1'b0;
        wb_val_o    = '0;
        unique case (mode_i)
            AM_IMM: begin
                nrd_o       = '0;
                early_val_o = fld_zx;
            end
            AM_REG: begin
                nrd_o       = '0;
                early_val_o = base_i;
            end
            AM_DIR:   ea_o = fld_zx;
            AM_IND: begin
                nrd_o = RCNT_W'(2);
                ea_o  = '0;
            end
            AM_RIND:  ea_o = base_i;
            AM_DISP:  ea_o = base_i + fld_sx;
            AM_PCREL: ea_o = pc_i + fld_sx;
            AM_STEP: begin
                wb_need_o = 1'b1;
                if (dec_i) begin
                    ea_o     = base_dec;
                    wb_val_o = base_dec;
                end else begin
                    ea_o     = base_i;
                    wb_val_o = base_inc;
                end
            end
            default: begin
                nrd_o = '0;
            end
        endcase
    end

    assign first_addr_o = (mode_i == AM_IND) ? fld_zx : ea_o;

endmodule

// File: rtl/oagu_seq.sv
module oagu_seq
    import oagu_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned RI = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RI-1:0]     rsel_i,
    input  logic [RCNT_W-1:0] nrd_i,
    input  logic [AW-1:0]     first_addr_i,
    input  logic [AW-1:0]     ea_i,
    input  logic [AW-1:0]     early_val_i,
    input  logic              wb_need_i,
    input  logic [AW-1:0]     wb_val_i,
    input  logic              mem_valid_i,
    input  logic [AW-1:0]     mem_data_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [AW-1:0]     ea_o,
    output logic [AW-1:0]     operand_o,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [RI-1:0]     wb_idx_o,
    output logic [AW-1:0]     wb_data_o
);

    typedef struct packed {
        ast_e          st;
        logic [AW-1:0] addr;
        logic [AW-1:0] ea;
        logic [AW-1:0] opnd;
        logic          done;
        logic          wb_pend;
        logic          wb_en;
        logic [AW-1:0] wb_val;
        logic [RI-1:0] idx;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic rd_fire;
    assign rd_fire = (seq_q.st != ST_IDLE) && mem_valid_i;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.wb_en = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.idx = rsel_i;
                    if (nrd_i == '0) begin
                        seq_d.done = 1'b1;
                        seq_d.ea   = '0;
                        seq_d.opnd = early_val_i;
                    end else begin
                        seq_d.addr    = first_addr_i;
                        seq_d.ea      = ea_i;
                        seq_d.wb_pend = wb_need_i;
                        seq_d.wb_val  = wb_val_i;
                        seq_d.st      = (nrd_i == RCNT_W'(2)) ? ST_PTR : ST_OPR;
                    end
                end
            end
            ST_PTR: begin
                if (rd_fire) begin
                    seq_d.addr = mem_data_i;
                    seq_d.ea   = mem_data_i;
                    seq_d.st   = ST_OPR;
                end
            end
            ST_OPR: begin
                if (rd_fire) begin
                    seq_d.opnd    = mem_data_i;
                    seq_d.done    = 1'b1;
                    seq_d.wb_en   = seq_q.wb_pend;
                    seq_d.wb_pend = 1'b0;
                    seq_d.st      = ST_IDLE;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_req_o  = (seq_q.st != ST_IDLE);
    assign mem_addr_o = seq_q.addr;
    assign ea_o       = seq_q.ea;
    assign operand_o  = seq_q.opnd;
    assign done_o     = seq_q.done;
    assign wb_en_o    = seq_q.wb_en;
    assign wb_idx_o   = seq_q.idx;
    assign wb_data_o  = seq_q.wb_val;

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import oagu_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned FW = 12,
    parameter int unsigned RI = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    mode_i,
    input  logic          dec_i,
    input  logic [FW-1:0] field_i,
    input  logic [RI-1:0] rsel_i,
    input  logic [AW-1:0] pc_i,
    output logic [RI-1:0] rf_addr_o,
    input  logic [AW-1:0] rf_data_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_valid_i,
    input  logic [AW-1:0] mem_data_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] operand_o,
    output logic          done_o,
    output logic          wb_en_o,
    output logic [RI-1:0] wb_idx_o,
    output logic [AW-1:0] wb_data_o
);

    logic [AW-1:0]     calc_ea;
    logic [AW-1:0]     calc_first;
    logic [AW-1:0]     calc_early;
    logic [RCNT_W-1:0] calc_nrd;
    logic              calc_wb_need;
    logic [AW-1:0]     calc_wb_val;

    assign rf_addr_o = rsel_i;

    oagu_ea_calc #(
        .AW(AW),
        .FW(FW)
    ) u_calc (
        .mode_i       (amode_e'(mode_i)),
        .dec_i        (dec_i),
        .field_i      (field_i),
        .base_i       (rf_data_i),
        .pc_i         (pc_i),
        .ea_o         (calc_ea),
        .first_addr_o (calc_first),
        .early_val_o  (calc_early),
        .nrd_o        (calc_nrd),
        .wb_need_o    (calc_wb_need),
        .wb_val_o     (calc_wb_val)
    );

    oagu_seq #(
        .AW(AW),
        .RI(RI)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .rsel_i       (rsel_i),
        .nrd_i        (calc_nrd),
        .first_addr_i (calc_first),
        .ea_i         (calc_ea),
        .early_val_i  (calc_early),
        .wb_need_i    (calc_wb_need),
        .wb_val_i     (calc_wb_val),
        .mem_valid_i  (mem_valid_i),
        .mem_data_i   (mem_data_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .ea_o         (ea_o),
        .operand_o    (operand_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .wb_idx_o     (wb_idx_o),
        .wb_data_o    (wb_data_o)
    );

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_valid_i,
    input logic [AW-1:0] ea_o,
    input logic [AW-1:0] operand_o,
    input logic          done_o,
    input logic          wb_en_o,
    input logic [AW-1:0] wb_data_o
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] ea_plus;
    assign ea_plus = ea_o + ONE;

    // R10: a waiting request keeps its address until valid
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R11: no completion can appear while a read is still waiting
    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> !done_o);

    // R12: completion is never seen with a request open
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);

    // R12: operand only moves on a completion
    p_opnd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(operand_o));

    // R8: write-back comes only together with completion
    p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    // R8: write enable is a single-cycle pulse
    p_wb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |=> !wb_en_o);

    // R9: written pointer equals the address used, or one past it
    p_wb_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> ((wb_data_o == ea_o) || (wb_data_o == ea_plus)));

endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .ea_o        (ea_o),
    .operand_o   (operand_o),
    .done_o      (done_o),
    .wb_en_o     (wb_en_o),
    .wb_data_o   (wb_data_o)
);

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;

    localparam int AW = 16;
    localparam int FW = 12;
    localparam int RI = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          start;
    logic [2:0]    mode;
    logic          dec;
    logic [FW-1:0] field;
    logic [RI-1:0] rsel;
    logic [AW-1:0] pc;
    logic [RI-1:0] rf_addr;
    logic [AW-1:0] rf_data;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid;
    logic [AW-1:0] mem_data;
    logic [AW-1:0] ea;
    logic [AW-1:0] operand;
    logic          done;
    logic          wb_en;
    logic [RI-1:0] wb_idx;
    logic [AW-1:0] wb_data;

    opaddr_gen #(.AW(AW), .FW(FW), .RI(RI)) u_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .dec_i(dec),
        .field_i(field), .rsel_i(rsel), .pc_i(pc), .rf_addr_o(rf_addr),
        .rf_data_i(rf_data), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_valid_i(mem_valid), .mem_data_i(mem_data), .ea_o(ea),
        .operand_o(operand), .done_o(done), .wb_en_o(wb_en),
        .wb_idx_o(wb_idx), .wb_data_o(wb_data)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    // register file seen by the design, written by its write-back port
    logic [AW-1:0] rf [8];
    // independent model of the register contents
    logic [AW-1:0] mdl [8];
    assign rf_data = rf[rf_addr];
    always @(posedge clk) if (wb_en) rf[wb_idx] <= wb_data;

    // memory: answers one cycle after a request, never two valids in a row
    logic [AW-1:0] mem [int];
    int            rd_seen;
    logic [AW-1:0] first_a;

    function automatic logic [AW-1:0] mrd(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a ^ 16'hA5A5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_data  <= '0;
        end else begin
            if (mem_req && mem_valid) begin
                if (rd_seen == 0) first_a = mem_addr;
                rd_seen++;
            end
            mem_valid <= mem_req && !mem_valid;
            mem_data  <= mrd(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic run_op(input logic [2:0] md, input bit dn, input logic [FW-1:0] fld,
                          input int rs, input logic [AW-1:0] pcv, input bit poke,
                          input string rq);
        logic [AW-1:0] base, fz, fs, ea_e, op_e, wbv, first_e;
        int nrd, lat;
        bit wbn;
        base = mdl[rs];
        fz   = AW'(fld);
        fs   = AW'($signed(fld));
        nrd = 1; ea_e = '0; op_e = '0; wbn = 0; wbv = '0;
        case (md)
            3'd0: begin nrd = 0; op_e = fz; end
            3'd1: begin nrd = 0; op_e = base; end
            3'd2: ea_e = fz;
            3'd3: begin nrd = 2; ea_e = mrd(fz); end
            3'd4: ea_e = base;
            3'd5: ea_e = base + fs;
            3'd6: ea_e = pcv + fs;
            default: begin
                wbn = 1;
                if (dn) begin ea_e = base - 16'd1; wbv = base - 16'd1; end
                else    begin ea_e = base;         wbv = base + 16'd1; end
            end
        endcase
        if (nrd > 0) op_e = mrd(ea_e);
        first_e = (md == 3'd3) ? fz : ea_e;
        lat = 2 * nrd;

        @(negedge clk);
        start = 1'b1; mode = md; dec = dn; field = fld; rsel = RI'(rs); pc = pcv;
        rd_seen = 0;
        @(posedge clk);
        for (int c = 0; c <= lat; c++) begin
            @(negedge clk);
            if (c == 0 && poke) begin
                mode = 3'd0; field = '1; rsel = RI'(rs + 1);
            end else begin
                start = 1'b0;
            end
            chk(done == (c == lat), {rq, " done timing (R10)"}, AW'(done), AW'(c == lat));
            chk(wb_en == (wbn && c == lat), {rq, " wb timing (R8)"}, AW'(wb_en),
                AW'(wbn && c == lat));
            if (c == lat) begin
                chk(ea == ea_e, {rq, " ea"}, ea, ea_e);
                chk(operand == op_e, {rq, " operand"}, operand, op_e);
                chk(rd_seen == nrd, {rq, " read count"}, AW'(rd_seen), AW'(nrd));
                if (nrd > 0)
                    chk(first_a == first_e, {rq, " first read addr"}, first_a, first_e);
                if (wbn) begin
                    chk(wb_idx == RI'(rs), {rq, " wb index"}, AW'(wb_idx), AW'(rs));
                    chk(wb_data == wbv, {rq, " wb data"}, wb_data, wbv);
                    mdl[rs] = wbv;
                end
            end
        end
        @(negedge clk);
        chk(!done && !mem_req && !wb_en, {rq, " quiet after completion (R11 R12)"},
            AW'({done, mem_req, wb_en}), '0);
        chk(operand == op_e, {rq, " operand held (R12)"}, operand, op_e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = '0; dec = 1'b0; field = '0; rsel = '0; pc = '0;
        rd_seen = 0; first_a = '0;
        for (int i = 0; i < 8; i++) begin rf[i] = AW'(i * 16'h0111); mdl[i] = rf[i]; end
        rf[1] = 16'd400;  mdl[1] = 16'd400;
        rf[2] = 16'd3;    mdl[2] = 16'd3;
        rf[3] = 16'hFFFF; mdl[3] = 16'hFFFF;
        rf[4] = 16'h0010; mdl[4] = 16'h0010;
        rf[5] = 16'h0000; mdl[5] = 16'h0000;
        mem[100] = 16'd500; mem[400] = 16'd700; mem[500] = 16'd800; mem[403] = 16'd900;
        mem[399] = 16'd123; mem[1] = 16'h0BAD; mem[196] = 16'h0C01; mem[206] = 16'h0C02;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req && !wb_en, "R12 reset controls", AW'({done, mem_req, wb_en}), '0);
        chk(ea == '0 && operand == '0, "R12 reset data", ea | operand, '0);

        run_op(3'd0, 0, 12'h0FF, 0, 16'd200, 0, "R1 immediate");
        run_op(3'd0, 0, 12'h800, 0, 16'd200, 0, "R1 immediate top bit");
        run_op(3'd1, 0, 12'h000, 1, 16'd200, 0, "R2 register");
        run_op(3'd2, 0, 12'd100, 0, 16'd200, 0, "R3 direct");
        run_op(3'd3, 0, 12'd100, 0, 16'd200, 0, "R4 indirect");
        run_op(3'd4, 0, 12'h000, 1, 16'd200, 0, "R5 register-indirect");
        run_op(3'd5, 0, 12'd3,   1, 16'd200, 0, "R6 displacement");
        run_op(3'd5, 0, 12'hFFF, 1, 16'd200, 0, "R6 negative displacement");
        run_op(3'd5, 0, 12'd2,   3, 16'd200, 0, "R6 wrap");
        run_op(3'd6, 0, 12'hFFC, 0, 16'd200, 0, "R7 pc backward");
        run_op(3'd6, 0, 12'd6,   0, 16'd200, 0, "R7 pc forward");
        run_op(3'd7, 0, 12'h000, 4, 16'd200, 0, "R8 post-increment");
        run_op(3'd7, 0, 12'h000, 4, 16'd200, 0, "R8 post-increment again");
        run_op(3'd7, 1, 12'h000, 4, 16'd200, 0, "R9 pre-decrement");
        run_op(3'd7, 1, 12'h000, 5, 16'd200, 0, "R9 pre-decrement wrap");
        run_op(3'd4, 0, 12'h000, 5, 16'd200, 0, "R9 decremented pointer used");
        run_op(3'd2, 0, 12'd100, 0, 16'd200, 1, "R11 strobe during direct");
        run_op(3'd3, 0, 12'd100, 0, 16'd200, 1, "R11 strobe during indirect");
        run_op(3'd7, 0, 12'h000, 3, 16'd200, 1, "R11 strobe during step");
        finish_run();
    end

endmodule